// File: doc/BRIEF.md
# Receive DMA Channel with Overrun Recovery

This block moves received audio bytes into memory. Bytes arrive one per cycle into a 64-byte staging FIFO. Software writes a descriptor table pointer and starts the channel, which fetches a descriptor over a request/response port. Each descriptor gives a buffer address, a byte length and an invalid flag. Once the FIFO reaches a programmable fill level, the channel writes 32-bit words to the buffer over a bus-master write port. When the buffer length is used up, it steps to the next 8-byte descriptor entry.

The master port can end a write with accept, retry or abort. A retried word is re-issued unchanged, and a status bit stays high while it is outstanding. A byte that arrives while the FIFO is full is an overrun. With auto-recovery off, an overrun aborts the channel. With auto-recovery on, the channel does three things and then continues with the same descriptor: it pulses a write-back that clears the current descriptor's invalid flag, it flushes the FIFO, and it counts the error. The 21st overrun since the last start aborts the channel instead of recovering.

Register map, 16-bit, selected by `reg_addr`:
- 0: pointer bits 15..0
- 1: pointer bits 31..16
- 2: FIFO byte count (read-only)
- 3: command/status word:
  - bits 1..0: fill level
  - bit 2: auto-recovery enable
  - bit 3: invalid mask
  - bit 4: start (write) / running (read)
  - bit 5: clear abort (write-1)
  - bit 6: software abort (write-1)
  - bit 7: abort status (read-only)
  - bit 8: outstanding-retry status (read-only)

Top module: `rx_dma_chan`

## Requirements
- R1: The FIFO holds up to 64 bytes. Register 2 reads its current byte count. A byte that arrives while the FIFO is full is not stored.
- R2: A burst starts once the FIFO count is at least the level chosen by command bits 1..0: 0 selects 4 bytes, 1 selects 16, 2 selects 32 and 3 selects 48. A burst is level/4 words.
- R3: Registers 0 and 1 read back the pointer halves written to them. Writing 1 to command bit 4 while the channel is idle, no abort is pending and no retry is outstanding does three things: it flushes the FIFO, it sets running, and it fetches the descriptor at the full 32-bit pointer.
- R4: Each accepted write carries 4 FIFO bytes, with the oldest byte in data bits 7..0. The first write goes to the descriptor's buffer address, and each later write goes 4 bytes higher. Descriptor lengths are multiples of 4.
- R5: When a descriptor's length is used up, the channel adds 8 to the entry pointer and fetches the next entry.
- R6: A fetched descriptor whose invalid flag is set stops the channel, and abort status is not set. If command bit 3 is 1, the channel proceeds anyway.
- R7: After a retry response, the same address and data are re-issued until the write is accepted or aborted. Command bit 8 is 1 from the retry until that outcome.
- R8: Abort status (command bit 7) is set by any of three events: an abort response on the master port, writing 1 to command bit 6, or an overrun with auto-recovery off. The channel then halts, after any write in progress has completed.
- R9: Writing 1 to command bit 5 clears abort status, and writing 0 there leaves it unchanged. A start request is ignored while abort status is set.
- R10: With auto-recovery on, an overrun causes a recovery step once the current write has completed. In that step the channel pulses `desc_clr` with the current entry address, empties the FIFO and resumes the same descriptor.
- R11: The overrun counter is cleared by each start. The overrun that brings the counter to 21 (0x15) sets abort status, and no recovery step follows it.
- R12: After reset, the channel is idle, all registers read 0, and neither port is requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Received byte strobe |
| in_byte | input | 8 | Received byte |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| desc_req | output | 1 | Descriptor fetch request |
| desc_addr | output | 32 | Current descriptor entry address |
| desc_ack | input | 1 | Descriptor response valid |
| desc_buf_addr | input | 32 | Descriptor buffer address |
| desc_len | input | 16 | Descriptor byte length |
| desc_inv | input | 1 | Descriptor invalid flag |
| desc_clr | output | 1 | Pulse: clear invalid flag of entry at `desc_addr` |
| mw_req | output | 1 | Master write request |
| mw_addr | output | 32 | Master write address |
| mw_data | output | 32 | Master write data |
| mw_ack | input | 1 | Write accepted |
| mw_retry | input | 1 | Write must be retried |
| mw_abort | input | 1 | Write aborted |

## Verification
The bench walks every fill level with one byte short of the level and then exactly the level. A design with an off-by-one threshold or a swapped level code would start a burst early or late. It holds the master port in retry and watches the address and status bit: a design that popped the FIFO or moved the address on a retry would re-issue different data. It drives 21 overruns in a row with recovery on, where a counter limit off by one would abort on the 20th or recover on the 21st. It also checks that a restart clears that counter. Clear-abort with a zero bit, a start while aborted, an invalid descriptor with and without the mask, and the 65th byte into a full FIFO each target an effect that a careless decode would let through.

// File: rtl/rx_dma_pkg.sv
package rx_dma_pkg;
  localparam int FIFO_DEPTH = 64;
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
  localparam int WORD_BYTES = 4;
  localparam int PTR_BITS   = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_WRITE,
    ST_RECOVER
  } eng_state_t;

  typedef struct packed {
    logic [1:0] lvl_sel;
    logic       auto_rec;
    logic       inv_mask;
  } cmd_cfg_t;

  // Fill level in bytes that starts a burst.
  function automatic logic [CNT_W-1:0] fill_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return CNT_W'(4);
      2'd1:    return CNT_W'(16);
      2'd2:    return CNT_W'(32);
      default: return CNT_W'(48);
    endcase
  endfunction
endpackage

// File: rtl/rx_byte_fifo.sv
module rx_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int WB    = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [7:0]      push_byte,
  input  logic            pop,
  input  logic            flush,
  output logic [8*WB-1:0] head_word,
  output logic [CW-1:0]   count,
  output logic            full
);
  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]    count_q, count_d;
  logic             push_ok;

  assign full    = (count_q == CW'(DEPTH));
  assign count   = count_q;
  assign push_ok = push && !full && !flush;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
    end else begin
      if (push_ok) wr_ptr_d = wr_ptr_q + PTR_W'(1);
      if (pop)     rd_ptr_d = rd_ptr_q + PTR_W'(WB);
      case ({push_ok, pop})
        2'b10:   count_d = count_q + CW'(1);
        2'b01:   count_d = count_q - CW'(WB);
        2'b11:   count_d = count_q - CW'(WB - 1);
        default: count_d = count_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= push_byte;
  end

  for (genvar i = 0; i < WB; i++) begin : g_head
    assign head_word[8*i +: 8] = mem[rd_ptr_q + PTR_W'(i)];
  end

  // R1
  count_le_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));
  // R4
  pop_has_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !flush) |-> count_q >= CW'(WB));
  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count_q == '0);
endmodule

// File: rtl/rx_dma_regs.sv
module rx_dma_regs
  import rx_dma_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [1:0]          reg_addr,
  input  logic [15:0]         reg_wdata,
  input  logic [CW-1:0]       fifo_count,
  input  logic                running,
  input  logic                abort_st,
  input  logic                open_st,
  output logic [PTR_BITS-1:0] dtp,
  output cmd_cfg_t            cfg,
  output logic                start,
  output logic                clr_abort,
  output logic                sw_abort,
  output logic [15:0]         reg_rdata
);
  logic [PTR_BITS-1:0] dtp_q, dtp_d;
  cmd_cfg_t            cfg_q, cfg_d;
  logic                cmd_wr;

  assign cmd_wr    = reg_wr && (reg_addr == 2'd3);
  assign start     = cmd_wr && reg_wdata[4];
  assign clr_abort = cmd_wr && reg_wdata[5];
  assign sw_abort  = cmd_wr && reg_wdata[6];

  always_comb begin
    dtp_d = dtp_q;
    cfg_d = cfg_q;
    if (reg_wr && reg_addr == 2'd0) dtp_d[15:0]  = reg_wdata;
    if (reg_wr && reg_addr == 2'd1) dtp_d[31:16] = reg_wdata;
    if (cmd_wr) begin
      cfg_d.lvl_sel  = reg_wdata[1:0];
      cfg_d.auto_rec = reg_wdata[2];
      cfg_d.inv_mask = reg_wdata[3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dtp_q <= '0;
      cfg_q <= '0;
    end else begin
      dtp_q <= dtp_d;
      cfg_q <= cfg_d;
    end
  end

  assign dtp = dtp_q;
  assign cfg = cfg_q;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = dtp_q[15:0];
      2'd1:    reg_rdata = dtp_q[31:16];
      2'd2:    reg_rdata = 16'(fifo_count);
      default: reg_rdata = {7'd0, open_st, abort_st, 2'b00, running,
                            cfg_q.inv_mask, cfg_q.auto_rec, cfg_q.lvl_sel};
    endcase
  end
endmodule

// File: rtl/rx_dma_engine.sv
module rx_dma_engine
  import rx_dma_pkg::*;
#(
  parameter int CW          = CNT_W,
  parameter int WB          = WORD_BYTES,
  parameter int DEPTH       = FIFO_DEPTH,
  parameter int LEN_W       = 16,
  parameter int ENTRY_BYTES = 8,
  parameter int ERR_LIMIT   = 21,
  localparam int ERR_W      = $clog2(ERR_LIMIT + 1),
  localparam int BEAT_W     = $clog2(DEPTH / WB + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  cmd_cfg_t            cfg,
  input  logic [PTR_BITS-1:0] dtp,
  input  logic                start,
  input  logic                clr_abort,
  input  logic                sw_abort,
  input  logic [CW-1:0]       fifo_count,
  input  logic                ovr_evt,
  input  logic [8*WB-1:0]     head_word,
  output logic                fifo_pop,
  output logic                fifo_flush,
  output logic                desc_req,
  output logic [PTR_BITS-1:0] desc_addr,
  input  logic                desc_ack,
  input  logic [PTR_BITS-1:0] desc_buf_addr,
  input  logic [LEN_W-1:0]    desc_len,
  input  logic                desc_inv,
  output logic                desc_clr,
  output logic                mw_req,
  output logic [PTR_BITS-1:0] mw_addr,
  output logic [8*WB-1:0]     mw_data,
  input  logic                mw_ack,
  input  logic                mw_retry,
  input  logic                mw_abort,
  output logic                running,
  output logic                abort_st,
  output logic                open_st
);
  eng_state_t          state_q, state_d;
  logic [PTR_BITS-1:0] ent_q, ent_d, buf_q, buf_d;
  logic [LEN_W-1:0]    rem_q, rem_d;
  logic [BEAT_W-1:0]   beats_q, beats_d;
  logic [ERR_W-1:0]    err_q, err_d;
  logic                pend_q, pend_d, open_q, open_d;
  logic                halt_q, halt_d, abort_q, abort_d;
  logic                ovr_abort, abort_set;

  assign desc_req  = (state_q == ST_FETCH);
  assign desc_addr = ent_q;
  assign mw_req    = (state_q == ST_WRITE);
  assign mw_addr   = buf_q;
  assign mw_data   = head_word;
  assign running   = (state_q != ST_IDLE);
  assign abort_st  = abort_q;
  assign open_st   = open_q;

  // Overrun classification: abort or schedule a recovery step.
  always_comb begin
    ovr_abort = 1'b0;
    err_d     = err_q;
    pend_d    = pend_q;
    if (ovr_evt && state_q != ST_IDLE && !halt_q) begin
      if (!cfg.auto_rec) begin
        ovr_abort = 1'b1;
      end else if (!pend_q) begin
        err_d = err_q + ERR_W'(1);
        if (err_q == ERR_W'(ERR_LIMIT - 1)) ovr_abort = 1'b1;
        else                                pend_d    = 1'b1;
      end
    end
    if (state_q == ST_RECOVER) pend_d = 1'b0;
    if (state_q == ST_IDLE && start && !abort_q && !open_q) begin
      err_d  = '0;
      pend_d = 1'b0;
    end
  end

  assign abort_set = ovr_abort || sw_abort || (mw_req && mw_abort);

  always_comb begin
    state_d    = state_q;
    ent_d      = ent_q;
    buf_d      = buf_q;
    rem_d      = rem_q;
    beats_d    = beats_q;
    open_d     = open_q;
    fifo_pop   = 1'b0;
    fifo_flush = 1'b0;
    desc_clr   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start && !abort_q && !open_q) begin
          state_d    = ST_FETCH;
          ent_d      = dtp;
          fifo_flush = 1'b1;
        end
      end
      ST_FETCH: begin
        if (halt_q) begin
          state_d = ST_IDLE;
        end else if (desc_ack) begin
          if (desc_inv && !cfg.inv_mask) begin
            state_d = ST_IDLE;
          end else if (desc_len == '0) begin
            ent_d = ent_q + PTR_BITS'(ENTRY_BYTES);
          end else begin
            buf_d   = desc_buf_addr;
            rem_d   = desc_len;
            state_d = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (halt_q) begin
          state_d = ST_IDLE;
        end else if (pend_q) begin
          state_d = ST_RECOVER;
        end else if (fifo_count >= fill_level(cfg.lvl_sel)) begin
          beats_d = BEAT_W'(fill_level(cfg.lvl_sel) / CW'(WB));
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (mw_abort) begin
          open_d  = 1'b0;
          state_d = ST_IDLE;
        end else if (mw_retry) begin
          open_d = 1'b1;
        end else if (mw_ack) begin
          open_d   = 1'b0;
          fifo_pop = 1'b1;
          buf_d    = buf_q + PTR_BITS'(WB);
          beats_d  = beats_q - BEAT_W'(1);
          if (rem_q <= LEN_W'(WB)) begin
            rem_d   = '0;
            ent_d   = ent_q + PTR_BITS'(ENTRY_BYTES);
            state_d = halt_q ? ST_IDLE : ST_FETCH;
          end else begin
            rem_d = rem_q - LEN_W'(WB);
            if (halt_q)                     state_d = ST_IDLE;
            else if (pend_q)                state_d = ST_RECOVER;
            else if (beats_q == BEAT_W'(1)) state_d = ST_WAIT;
          end
        end
      end
      ST_RECOVER: begin
        desc_clr   = 1'b1;
        fifo_flush = 1'b1;
        state_d    = halt_q ? ST_IDLE : ST_WAIT;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    halt_d = halt_q || abort_set;
    if (state_d == ST_IDLE) halt_d = 1'b0;
    abort_d = abort_q;
    if (abort_set)      abort_d = 1'b1;
    else if (clr_abort) abort_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ent_q   <= '0;
      buf_q   <= '0;
      rem_q   <= '0;
      beats_q <= '0;
      err_q   <= '0;
      pend_q  <= 1'b0;
      open_q  <= 1'b0;
      halt_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ent_q   <= ent_d;
      buf_q   <= buf_d;
      rem_q   <= rem_d;
      beats_q <= beats_d;
      err_q   <= err_d;
      pend_q  <= pend_d;
      open_q  <= open_d;
      halt_q  <= halt_d;
      abort_q <= abort_d;
    end
  end

  // R7
  retry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_req && mw_retry && !mw_abort) |=> (mw_req && $stable(mw_addr) && $stable(mw_data)));
  // R7
  open_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_req && mw_retry && !mw_abort) |=> open_st);
  // R8
  bus_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_req && mw_abort) |=> (abort_st && !mw_req));
  // R5
  entry_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_req && mw_ack && !mw_retry && !mw_abort && rem_q <= LEN_W'(WB))
      |=> desc_addr == $past(desc_addr) + PTR_BITS'(ENTRY_BYTES));
  // R11
  err_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q <= ERR_W'(ERR_LIMIT));
endmodule

// File: rtl/rx_dma_chan.sv
module rx_dma_chan
  import rx_dma_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int ENTRY_BYTES = 8,
  parameter int ERR_LIMIT   = 21
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [7:0]          in_byte,
  input  logic                reg_wr,
  input  logic [1:0]          reg_addr,
  input  logic [15:0]         reg_wdata,
  output logic [15:0]         reg_rdata,
  output logic                desc_req,
  output logic [PTR_BITS-1:0] desc_addr,
  input  logic                desc_ack,
  input  logic [PTR_BITS-1:0] desc_buf_addr,
  input  logic [LEN_W-1:0]    desc_len,
  input  logic                desc_inv,
  output logic                desc_clr,
  output logic                mw_req,
  output logic [PTR_BITS-1:0] mw_addr,
  output logic [8*WORD_BYTES-1:0] mw_data,
  input  logic                mw_ack,
  input  logic                mw_retry,
  input  logic                mw_abort
);
  logic [CNT_W-1:0]        fifo_count;
  logic                    fifo_full, fifo_pop, fifo_flush;
  logic [8*WORD_BYTES-1:0] head_word;
  logic [PTR_BITS-1:0]     dtp;
  cmd_cfg_t                cfg;
  logic                    start, clr_abort, sw_abort;
  logic                    running, abort_st, open_st;
  logic                    ovr_evt;

  assign ovr_evt = in_valid && fifo_full;

  rx_byte_fifo #(.DEPTH(FIFO_DEPTH), .WB(WORD_BYTES)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (in_valid),
    .push_byte (in_byte),
    .pop       (fifo_pop),
    .flush     (fifo_flush),
    .head_word (head_word),
    .count     (fifo_count),
    .full      (fifo_full)
  );

  rx_dma_regs #(.CW(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .fifo_count (fifo_count),
    .running    (running),
    .abort_st   (abort_st),
    .open_st    (open_st),
    .dtp        (dtp),
    .cfg        (cfg),
    .start      (start),
    .clr_abort  (clr_abort),
    .sw_abort   (sw_abort),
    .reg_rdata  (reg_rdata)
  );

  rx_dma_engine #(
    .CW          (CNT_W),
    .WB          (WORD_BYTES),
    .DEPTH       (FIFO_DEPTH),
    .LEN_W       (LEN_W),
    .ENTRY_BYTES (ENTRY_BYTES),
    .ERR_LIMIT   (ERR_LIMIT)
  ) u_eng (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg           (cfg),
    .dtp           (dtp),
    .start         (start),
    .clr_abort     (clr_abort),
    .sw_abort      (sw_abort),
    .fifo_count    (fifo_count),
    .ovr_evt       (ovr_evt),
    .head_word     (head_word),
    .fifo_pop      (fifo_pop),
    .fifo_flush    (fifo_flush),
    .desc_req      (desc_req),
    .desc_addr     (desc_addr),
    .desc_ack      (desc_ack),
    .desc_buf_addr (desc_buf_addr),
    .desc_len      (desc_len),
    .desc_inv      (desc_inv),
    .desc_clr      (desc_clr),
    .mw_req        (mw_req),
    .mw_addr       (mw_addr),
    .mw_data       (mw_data),
    .mw_ack        (mw_ack),
    .mw_retry      (mw_retry),
    .mw_abort      (mw_abort),
    .running       (running),
    .abort_st      (abort_st),
    .open_st       (open_st)
  );
endmodule

// File: tb/rx_dma_chan_test.sv
module rx_dma_chan_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_byte;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        desc_req, desc_ack, desc_inv, desc_clr;
  logic [31:0] desc_addr, desc_buf_addr;
  logic [15:0] desc_len;
  logic        mw_req, mw_ack, mw_retry, mw_abort;
  logic [31:0] mw_addr, mw_data;

  int          checks = 0;
  int          errors = 0;
  logic        done = 1'b0;
  logic [7:0]  nb;
  logic [1:0]  mw_mode;
  logic [31:0] inv_addr;
  logic [15:0] d_len;
  int          acks = 0, fetches = 0, clrs = 0;
  logic [31:0] last_addr, last_data, last_fetch, last_clr;

  localparam logic [15:0] C_START = 16'h0010;
  localparam logic [15:0] C_CLR   = 16'h0020;
  localparam logic [15:0] C_SWAB  = 16'h0040;
  localparam logic [31:0] DTP     = 32'h1234_5678;

  // {level code, level in bytes}
  localparam logic [8:0] VEC [4] = '{
    {2'd0, 7'd4}, {2'd1, 7'd16}, {2'd2, 7'd32}, {2'd3, 7'd48}
  };

  always #10 clk = ~clk;

  rx_dma_chan uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .desc_req(desc_req), .desc_addr(desc_addr), .desc_ack(desc_ack),
    .desc_buf_addr(desc_buf_addr), .desc_len(desc_len), .desc_inv(desc_inv),
    .desc_clr(desc_clr), .mw_req(mw_req), .mw_addr(mw_addr), .mw_data(mw_data),
    .mw_ack(mw_ack), .mw_retry(mw_retry), .mw_abort(mw_abort)
  );

  assign desc_ack      = desc_req;
  assign desc_buf_addr = desc_addr + 32'h0001_0000;
  assign desc_len      = d_len;
  assign desc_inv      = (desc_addr == inv_addr);
  assign mw_ack        = mw_req && (mw_mode == 2'd0);
  assign mw_retry      = mw_req && (mw_mode == 2'd1);
  assign mw_abort      = mw_req && (mw_mode == 2'd2);

  always @(posedge clk) begin
    if (mw_ack) begin
      acks      <= acks + 1;
      last_addr <= mw_addr;
      last_data <= mw_data;
    end
    if (desc_req && desc_ack) begin
      fetches    <= fetches + 1;
      last_fetch <= desc_addr;
    end
    if (desc_clr) begin
      clrs     <= clrs + 1;
      last_clr <= desc_addr;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic push(input int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_byte  = nb;
      nb       = nb + 8'd1;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic [31:0] a0;
    int          base;
    rst_n = 1'b0; in_valid = 1'b0; in_byte = '0; reg_wr = 1'b0;
    reg_addr = '0; reg_wdata = '0; nb = '0; mw_mode = 2'd0;
    inv_addr = 32'hFFFF_FFFF; d_len = 16'd16;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    rd(2'd3, r); chk("R12 cmd", r, 0);
    rd(2'd2, r); chk("R12 count", r, 0);
    chk("R12 desc_req", desc_req, 0);
    chk("R12 mw_req", mw_req, 0);

    // R3 pointer halves
    wr(2'd0, DTP[15:0]);
    wr(2'd1, DTP[31:16]);
    rd(2'd0, r); chk("R3 low half", r, DTP[15:0]);
    rd(2'd1, r); chk("R3 high half", r, DTP[31:16]);

    // R3 start fetches at pointer
    wr(2'd3, C_START);
    step(2);
    chk("R3 fetch address", last_fetch, DTP);
    rd(2'd3, r); chk("R3 running", r[4], 1);
    d_len = 16'd4096;

    // R4 word packing and addressing
    nb = 8'h10;
    push(4); step(4);
    chk("R4 first addr", last_addr, DTP + 32'h0001_0000);
    chk("R4 byte order", last_data, 32'h1312_1110);
    push(4); step(4);
    chk("R4 next addr", last_addr, DTP + 32'h0001_0004);
    chk("R4 next data", last_data, 32'h1716_1514);
    push(8); step(6);
    // R5 entry step after 16 bytes
    chk("R5 next entry", last_fetch, DTP + 32'd8);
    chk("R5 fetch count", fetches, 2);

    // R2 fill-level table
    foreach (VEC[k]) begin
      mw_mode = 2'd1;
      wr(2'd3, {14'd0, VEC[k][8:7]});
      push(int'(VEC[k][6:0]) - 1); step(3);
      chk("R2 below level", mw_req, 0);
      push(1); step(3);
      chk("R2 at level", mw_req, 1);
      rd(2'd3, r); chk("R7 open while retry", r[8], 1);
      a0 = mw_addr; step(2);
      chk("R7 addr held", mw_addr, a0);
      mw_mode = 2'd0;
      step(20);
      rd(2'd3, r); chk("R7 open cleared", r[8], 0);
      rd(2'd2, r); chk("R1 drained count", r, 0);
    end

    // R8 software abort, R9 clear semantics
    wr(2'd3, 16'h0000);
    mw_mode = 2'd1;
    push(4); step(3);
    wr(2'd3, C_SWAB);
    rd(2'd3, r); chk("R8 sw abort status", r[7], 1);
    chk("R7 still retrying", mw_req, 1);
    mw_mode = 2'd0; step(3);
    rd(2'd3, r); chk("R8 halted", r[4], 0);
    wr(2'd3, 16'h0000);
    rd(2'd3, r); chk("R9 zero leaves abort", r[7], 1);
    wr(2'd3, C_START); step(2);
    rd(2'd3, r); chk("R9 start ignored", r[4], 0);
    wr(2'd3, C_CLR);
    rd(2'd3, r); chk("R9 cleared", r[7], 0);

    // R8 bus abort
    wr(2'd3, C_START);
    mw_mode = 2'd2;
    push(4); step(4);
    rd(2'd3, r);
    chk("R8 bus abort status", r[7], 1);
    chk("R8 bus abort halt", r[4], 0);
    chk("R7 open after abort", r[8], 0);
    wr(2'd3, C_CLR);
    mw_mode = 2'd0;

    // R6 invalid descriptor
    inv_addr = DTP;
    wr(2'd3, C_START); step(3);
    rd(2'd3, r);
    chk("R6 invalid stops", r[4], 0);
    chk("R6 no abort", r[7], 0);
    wr(2'd3, C_START | 16'h0008); step(3);
    rd(2'd3, r); chk("R6 mask proceeds", r[4], 1);
    wr(2'd3, C_SWAB); step(2);
    wr(2'd3, C_CLR);
    inv_addr = 32'hFFFF_FFFF;

    // R1/R8 overrun without recovery
    mw_mode = 2'd1;
    wr(2'd3, C_START | 16'h0003);
    push(64);
    rd(2'd2, r); chk("R1 full count", r, 64);
    rd(2'd3, r); chk("R8 no abort yet", r[7], 0);
    push(1);
    rd(2'd2, r); chk("R1 extra byte dropped", r, 64);
    rd(2'd3, r); chk("R8 overrun abort", r[7], 1);
    mw_mode = 2'd0; step(4);
    rd(2'd3, r); chk("R8 overrun halt", r[4], 0);
    wr(2'd3, C_CLR);

    // R10/R11 auto recovery up to the limit
    base = clrs;
    wr(2'd3, C_START | 16'h0007);
    for (int k = 1; k <= 21; k++) begin
      mw_mode = 2'd1;
      push(65);
      mw_mode = 2'd0;
      step(6);
      rd(2'd3, r);
      if (k < 21) begin
        chk("R11 no abort before limit", r[7], 0);
        if (k == 1) begin
          chk("R10 clear pulse", clrs, base + 1);
          chk("R10 clear entry", last_clr, DTP);
          rd(2'd2, r); chk("R10 flushed", r, 0);
          rd(2'd3, r); chk("R10 resumes", r[4], 1);
        end
      end else begin
        chk("R11 abort at limit", r[7], 1);
        chk("R11 halted at limit", r[4], 0);
        chk("R11 recoveries", clrs, base + 20);
      end
    end

    // R11 start resets the counter
    wr(2'd3, C_CLR);
    base = clrs;
    wr(2'd3, C_START | 16'h0007);
    mw_mode = 2'd1;
    push(65);
    mw_mode = 2'd0;
    step(6);
    rd(2'd3, r);
    chk("R11 counter reset abort", r[7], 0);
    chk("R11 counter reset recovers", clrs, base + 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule